// File: doc/BRIEF.md
# Little-Endian Bus Width Matcher

This block sits on the data path of a FIFO whose storage is organised in 36-bit words while the user-facing ports may be narrower. On the write side it collects 9-bit or 18-bit beats and assembles them into full 36-bit words for storage. On the read side it splits 36-bit words taken from storage into 9-bit or 18-bit beats. Sub-words are ordered little-endian. The first narrow beat written lands in the least significant bits of the assembled word. The least significant part of a stored word is the first beat delivered.

All four data interfaces use valid/ready handshakes. A transfer happens on a rising clock edge where valid and ready are both high. A source keeps valid and data steady until the transfer takes place. The block follows that rule on its own outputs. `in_ready_o` drops only when the final beat of a word arrives while the assembled word is still waiting to be taken. `rd_ready_o` stays low while a stored word still has sub-words to deliver. It goes high in the same cycle that the last sub-word is accepted, so there is no bubble between words.

A 3-bit width code is captured on every clock edge while the synchronous reset is held, and it stays fixed until the next reset. Illegal codes raise a configuration error and freeze both directions.

Top module: `bus_width_matcher`

## Requirements
- R1: The width code on `mode_i` is captured on each clock edge while `rst_ni` is low and then held until the next reset; later changes on `mode_i` have no effect. Codes: 0 = 36 in / 36 out, 1 = 18 in / 36 out, 2 = 9 in / 36 out, 3 = 36 in / 18 out, 4 = 36 in / 9 out.
- R2: Codes 5, 6 and 7 drive `cfg_err_o` high and hold `in_ready_o`, `rd_ready_o`, `wr_valid_o` and `out_valid_o` low whatever the inputs do; legal codes keep `cfg_err_o` low.
- R3: With 9-bit input, only `in_data_i[8:0]` is used, and a word is offered on `wr_data_o` only after four beats; beat n of a word (n = 0..3) occupies bits [9n+8:9n].
- R4: With 18-bit input, only `in_data_i[17:0]` is used, and a word is offered after two beats; the first beat occupies bits [17:0] and the second bits [35:18].
- R5: With 36-bit input, every accepted beat appears unchanged on `wr_data_o`, in input order, with one word per beat.
- R6: With 9-bit output, each stored word yields four beats on `out_data_o[8:0]`, bits [8:0] first and bits [35:27] last; `out_data_o[35:9]` is zero.
- R7: With 18-bit output, each stored word yields two beats on `out_data_o[17:0]`, bits [17:0] first; `out_data_o[35:18]` is zero.
- R8: While `out_valid_o` is high and `out_ready_o` is low, `out_data_o` holds, `out_valid_o` stays high and `rd_ready_o` is low. When the last sub-word of a word is accepted, `rd_ready_o` is high in that same cycle.
- R9: While `wr_valid_o` is high and `wr_ready_i` is low, `wr_valid_o` and `wr_data_o` hold.
- R10: Reset empties the assembly and unpack registers and discards any partly built or partly delivered word. After reset, `wr_valid_o` and `out_valid_o` are low and, for a legal code, both ready outputs are high.
- R11: With 36-bit output, every stored word accepted on the read side appears unchanged on `out_data_o`, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| mode_i | input | 3 | Width code, captured during reset |
| cfg_err_o | output | 1 | Captured width code is illegal |
| in_valid_i | input | 1 | Narrow write beat valid |
| in_ready_o | output | 1 | Narrow write beat accepted |
| in_data_i | input | 36 | Write beat, narrow data in the low bits |
| wr_valid_o | output | 1 | Assembled word valid toward storage |
| wr_ready_i | input | 1 | Storage takes the assembled word |
| wr_data_o | output | 36 | Assembled 36-bit word |
| rd_valid_i | input | 1 | Stored word offered by storage |
| rd_ready_o | output | 1 | Stored word accepted |
| rd_data_i | input | 36 | Stored 36-bit word |
| out_valid_o | output | 1 | Narrow read beat valid |
| out_ready_i | input | 1 | Consumer takes the read beat |
| out_data_o | output | 36 | Read beat, zero-extended above the narrow width |

## Verification
Two events can fall in the same cycle: the final sub-word of a stored word leaves on the output, and the next stored word is accepted on the read side. The same is true on the write side, where the final narrow beat arrives while storage takes the previously assembled word. The bench runs each legal code with overlapping, staggered valid and ready patterns on all four interfaces so that these overlaps recur many times. It judges each case in two ways. Every word and beat must match its arithmetically predicted value in order. In any cycle that carries a last sub-word together with a pending stored word, `rd_ready_o` must be high.

// File: rtl/bwm_pkg.sv
package bwm_pkg;

  localparam int LANES = 4;

  typedef enum logic [1:0] {
    SW_FULL    = 2'd0,
    SW_HALF    = 2'd1,
    SW_QUARTER = 2'd2
  } sub_w_e;

  typedef struct packed {
    sub_w_e in_w;
    sub_w_e out_w;
    logic   bad;
  } width_cfg_t;

  // index of the final beat of a word for a given side width
  function automatic logic [1:0] final_beat(sub_w_e w);
    case (w)
      SW_HALF:    final_beat = 2'd1;
      SW_QUARTER: final_beat = 2'd3;
      default:    final_beat = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/bwm_cfg.sv
module bwm_cfg #(
  parameter int CODE_W = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [CODE_W-1:0]   mode_i,
  output bwm_pkg::width_cfg_t cfg_o
);
  import bwm_pkg::*;

  logic [CODE_W-1:0] code_q;

  // captured only while reset is held
  always_ff @(posedge clk_i) begin
    if (!rst_ni) code_q <= mode_i;
  end

  always_comb begin
    cfg_o = '{in_w: SW_FULL, out_w: SW_FULL, bad: 1'b0};
    case (code_q)
      CODE_W'(0): ;
      CODE_W'(1): cfg_o.in_w  = SW_HALF;
      CODE_W'(2): cfg_o.in_w  = SW_QUARTER;
      CODE_W'(3): cfg_o.out_w = SW_HALF;
      CODE_W'(4): cfg_o.out_w = SW_QUARTER;
      default:    cfg_o.bad   = 1'b1;
    endcase
  end

endmodule

// File: rtl/bwm_pack.sv
module bwm_pack #(
  parameter int WORD_W = 36
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  bwm_pkg::sub_w_e     sub_w_i,
  input  logic                in_valid_i,
  output logic                in_ready_o,
  input  logic [WORD_W-1:0]   in_data_i,
  output logic                wr_valid_o,
  input  logic                wr_ready_i,
  output logic [WORD_W-1:0]   wr_data_o
);
  import bwm_pkg::*;

  localparam int LANE_W = WORD_W / LANES;

  logic [1:0]        cnt_q;
  logic [WORD_W-1:0] acc_q;
  logic [WORD_W-1:0] word_d;
  logic [WORD_W-1:0] hold_q;
  logic              hold_vld_q;
  logic              is_final;
  logic              fire;

  assign is_final   = (cnt_q == final_beat(sub_w_i));
  assign in_ready_o = en_i && (!is_final || !hold_vld_q || wr_ready_i);
  assign fire       = in_valid_i && in_ready_o;

  // each 9-bit lane of the word picks its source and write beat from the width
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic              hit;
    logic [LANE_W-1:0] src;
    always_comb begin
      case (sub_w_i)
        SW_QUARTER: begin
          hit = (cnt_q == 2'(j));
          src = in_data_i[LANE_W-1:0];
        end
        SW_HALF: begin
          hit = (cnt_q == 2'(j / 2));
          src = in_data_i[(j % 2)*LANE_W +: LANE_W];
        end
        default: begin
          hit = 1'b1;
          src = in_data_i[j*LANE_W +: LANE_W];
        end
      endcase
    end
    assign word_d[j*LANE_W +: LANE_W] = hit ? src : acc_q[j*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      acc_q      <= '0;
      hold_q     <= '0;
      hold_vld_q <= 1'b0;
    end else begin
      if (hold_vld_q && wr_ready_i) hold_vld_q <= 1'b0;
      if (fire) begin
        acc_q <= word_d;
        if (is_final) begin
          cnt_q      <= '0;
          hold_q     <= word_d;
          hold_vld_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 2'd1;
        end
      end
    end
  end

  assign wr_valid_o = hold_vld_q;
  assign wr_data_o  = hold_q;

endmodule

// File: rtl/bwm_unpack.sv
module bwm_unpack #(
  parameter int WORD_W = 36
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  bwm_pkg::sub_w_e     sub_w_i,
  input  logic                rd_valid_i,
  output logic                rd_ready_o,
  input  logic [WORD_W-1:0]   rd_data_i,
  output logic                out_valid_o,
  input  logic                out_ready_i,
  output logic [WORD_W-1:0]   out_data_o
);
  import bwm_pkg::*;

  localparam int LANE_W = WORD_W / LANES;
  localparam int HALF_W = 2 * LANE_W;

  logic [WORD_W-1:0] word_q;
  logic              vld_q;
  logic [1:0]        cnt_q;
  logic              is_final;
  logic              drain;
  logic              load;

  assign is_final   = (cnt_q == final_beat(sub_w_i));
  assign drain      = vld_q && out_ready_i && is_final;
  assign rd_ready_o = en_i && (!vld_q || drain);
  assign load       = rd_valid_i && rd_ready_o;

  always_comb begin
    out_data_o = '0;
    case (sub_w_i)
      SW_QUARTER: out_data_o[LANE_W-1:0] = word_q[cnt_q*LANE_W +: LANE_W];
      SW_HALF:    out_data_o[HALF_W-1:0] = word_q[cnt_q[0]*HALF_W +: HALF_W];
      default:    out_data_o             = word_q;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      word_q <= '0;
      vld_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (vld_q && out_ready_i) begin
        if (is_final) begin
          cnt_q <= '0;
          vld_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 2'd1;
        end
      end
      if (load) begin
        word_q <= rd_data_i;
        vld_q  <= 1'b1;
      end
    end
  end

  assign out_valid_o = vld_q;

endmodule

// File: rtl/bus_width_matcher.sv
module bus_width_matcher #(
  parameter int WORD_W = 36,
  parameter int CODE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] mode_i,
  output logic              cfg_err_o,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [WORD_W-1:0] in_data_i,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [WORD_W-1:0] wr_data_o,
  input  logic              rd_valid_i,
  output logic              rd_ready_o,
  input  logic [WORD_W-1:0] rd_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [WORD_W-1:0] out_data_o
);
  import bwm_pkg::*;

  width_cfg_t cfg;
  logic       run;

  bwm_cfg #(.CODE_W(CODE_W)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode_i),
    .cfg_o  (cfg)
  );

  assign run       = !cfg.bad;
  assign cfg_err_o = cfg.bad;

  bwm_pack #(.WORD_W(WORD_W)) u_pack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (run),
    .sub_w_i    (cfg.in_w),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .in_data_i  (in_data_i),
    .wr_valid_o (wr_valid_o),
    .wr_ready_i (wr_ready_i),
    .wr_data_o  (wr_data_o)
  );

  bwm_unpack #(.WORD_W(WORD_W)) u_unpack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (run),
    .sub_w_i     (cfg.out_w),
    .rd_valid_i  (rd_valid_i),
    .rd_ready_o  (rd_ready_o),
    .rd_data_i   (rd_data_i),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_data_o  (out_data_o)
  );

endmodule

// File: rtl/bwm_checker.sv
module bwm_checker #(
  parameter int WORD_W = 36
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_err_o,
  input logic              in_ready_o,
  input logic              wr_valid_o,
  input logic              wr_ready_i,
  input logic [WORD_W-1:0] wr_data_o,
  input logic              rd_ready_o,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [WORD_W-1:0] out_data_o,
  input bwm_pkg::sub_w_e   out_w_i
);
  import bwm_pkg::*;

  localparam int LANE_W = WORD_W / LANES;

  a_r1_mode_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> $stable(cfg_err_o));

  a_r2_cfg_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> (!in_ready_o && !rd_ready_o && !wr_valid_o && !out_valid_o));

  a_r6_quarter_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_w_i == SW_QUARTER) |-> (out_data_o[WORD_W-1:LANE_W] == '0));

  a_r7_half_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_w_i == SW_HALF) |-> (out_data_o[WORD_W-1:2*LANE_W] == '0));

  a_r8_out_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

  a_r8_no_early_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !rd_ready_o);

  a_r9_wr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_data_o)));

endmodule

bind bus_width_matcher bwm_checker #(.WORD_W(WORD_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_err_o   (cfg_err_o),
  .in_ready_o  (in_ready_o),
  .wr_valid_o  (wr_valid_o),
  .wr_ready_i  (wr_ready_i),
  .wr_data_o   (wr_data_o),
  .rd_ready_o  (rd_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o),
  .out_w_i     (cfg.out_w)
);

// File: tb/test_bus_width_matcher.sv
module test_bus_width_matcher;

  localparam int CLK_PERIOD = 10;
  localparam int NW         = 12;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  mode;
  logic        cfg_err;
  logic        in_valid, in_ready;
  logic [35:0] in_data;
  logic        wr_valid, wr_ready;
  logic [35:0] wr_data;
  logic        rd_valid, rd_ready;
  logic [35:0] rd_data;
  logic        out_valid, out_ready;
  logic [35:0] out_data;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bus_width_matcher i_bus_width_matcher (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .cfg_err_o(cfg_err),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .wr_valid_o(wr_valid), .wr_ready_i(wr_ready), .wr_data_o(wr_data),
    .rd_valid_i(rd_valid), .rd_ready_o(rd_ready), .rd_data_i(rd_data),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data)
  );

  task automatic check(input bit ok, input string req, input logic [35:0] act,
                       input logic [35:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int in_w_of(input int m);
    return (m == 1) ? 18 : (m == 2) ? 9 : 36;
  endfunction

  function automatic int out_w_of(input int m);
    return (m == 3) ? 18 : (m == 4) ? 9 : 36;
  endfunction

  function automatic logic [35:0] d_in(input int i);
    return {4'(i), 32'(i * 32'h9E3779B1 + 32'h1234567)};
  endfunction

  function automatic logic [35:0] e_word(input int k);
    return {4'(~k), 32'((k * 32'h85EBCA6B) ^ 32'hC2B2AE35)};
  endfunction

  function automatic logic [35:0] exp_pack(input int m, input int k);
    logic [35:0] w;
    case (in_w_of(m))
      9:  for (int j = 0; j < 4; j++) w[j*9 +: 9] = d_in(4*k + j)[8:0];
      18: w = {d_in(2*k + 1)[17:0], d_in(2*k)[17:0]};
      default: w = d_in(k);
    endcase
    return w;
  endfunction

  function automatic logic [35:0] exp_unpack(input int m, input int i);
    logic [35:0] w = '0;
    logic [35:0] src;
    case (out_w_of(m))
      9:  begin src = e_word(i / 4); w[8:0]  = src[(i % 4)*9 +: 9];  end
      18: begin src = e_word(i / 2); w[17:0] = src[(i % 2)*18 +: 18]; end
      default: w = e_word(i);
    endcase
    return w;
  endfunction

  function automatic string tag_pack(input int m);
    case (in_w_of(m))
      9: return "R3"; 18: return "R4"; default: return "R5";
    endcase
  endfunction

  function automatic string tag_unpack(input int m);
    case (out_w_of(m))
      9: return "R6"; 18: return "R7"; default: return "R11";
    endcase
  endfunction

  task automatic idle();
    in_valid = 0; in_data = '0; wr_ready = 0;
    rd_valid = 0; rd_data = '0; out_ready = 0;
  endtask

  task automatic do_reset(input int m);
    @(negedge clk);
    rst_n = 0; mode = 3'(m); idle();
    repeat (2) @(negedge clk);
    rst_n = 1;
    mode = ~3'(m); // R1: later changes must be ignored
  endtask

  task automatic run_legal(input int m);
    int nb = NW * (36 / in_w_of(m));
    int ns = NW * (36 / out_w_of(m));
    int ratio = 36 / out_w_of(m);
    // R10: leave partial words in flight, then reset them away
    do_reset(m);
    @(negedge clk);
    in_valid = 1; in_data = '1; rd_valid = 1; rd_data = '1;
    @(negedge clk);
    in_valid = 1; rd_valid = 0; out_ready = 1;
    @(negedge clk);
    idle();
    do_reset(m);
    #1;
    check(!wr_valid && !out_valid, "R10 valids low after reset", {34'd0, wr_valid, out_valid}, '0);
    check(in_ready && rd_ready && !cfg_err, "R10/R1 ready after reset",
          {33'd0, in_ready, rd_ready, cfg_err}, 36'd6);
    fork
      begin : producer
        int idx = 0;
        while (idx < nb) begin
          @(negedge clk);
          in_valid = (cyc % 3 != 1);
          in_data  = d_in(idx);
          #1;
          if (in_valid && in_ready) idx++;
        end
        @(negedge clk) in_valid = 0;
      end
      begin : wr_sink
        int k = 0;
        bit held = 0;
        logic [35:0] held_d = '0;
        while (k < NW) begin
          @(negedge clk);
          wr_ready = (cyc % 4 != 2);
          #1;
          if (held) begin
            check(wr_valid && wr_data == held_d, "R9 word held under back-pressure", wr_data, held_d);
            held = 0;
          end
          if (wr_valid) begin
            if (wr_ready) begin
              check(wr_data == exp_pack(m, k), tag_pack(m), wr_data, exp_pack(m, k));
              k++;
            end else begin
              held = 1; held_d = wr_data;
            end
          end
        end
        @(negedge clk) wr_ready = 0;
      end
      begin : rd_source
        int k = 0;
        while (k < NW) begin
          @(negedge clk);
          rd_valid = (cyc % 5 != 3);
          rd_data  = e_word(k);
          #1;
          if (rd_valid && rd_ready) k++;
        end
        @(negedge clk) rd_valid = 0;
      end
      begin : out_sink
        int i = 0;
        bit held = 0;
        logic [35:0] held_d = '0;
        while (i < ns) begin
          @(negedge clk);
          out_ready = (cyc % 3 != 0);
          #1;
          if (held) begin
            check(out_valid && out_data == held_d, "R8 beat held under back-pressure", out_data, held_d);
            held = 0;
          end
          if (out_valid) begin
            if (out_ready) begin
              check(out_data == exp_unpack(m, i), tag_unpack(m), out_data, exp_unpack(m, i));
              if (i % ratio == ratio - 1 && rd_valid)
                check(rd_ready, "R8 next word taken with last sub-word", {35'd0, rd_ready}, 36'd1);
              i++;
            end else begin
              check(!rd_ready, "R8 no new word while beat pending", {35'd0, rd_ready}, 36'd0);
              held = 1; held_d = out_data;
            end
          end
        end
        @(negedge clk) out_ready = 0;
      end
    join
  endtask

  task automatic run_illegal(input int m);
    do_reset(m);
    #1;
    check(cfg_err && !in_ready && !rd_ready, "R2 illegal code blocks",
          {33'd0, cfg_err, in_ready, rd_ready}, 36'd4);
    @(negedge clk);
    in_valid = 1; in_data = d_in(m); rd_valid = 1; rd_data = e_word(m);
    wr_ready = 1; out_ready = 1;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      #1;
      check(!wr_valid && !out_valid && cfg_err, "R2 no traffic on illegal code",
            {33'd0, wr_valid, out_valid, cfg_err}, 36'd1);
    end
    idle();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    rst_n = 0; mode = '0; idle();
    for (int m = 0; m < 5; m++) run_legal(m);
    for (int m = 5; m < 8; m++) run_illegal(m);
    run_legal(2); // legal again after an illegal code (R1)
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule